// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block supervises read-after-write hazards in a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register numbers of the instruction in decode with the destinations of the instructions in execute and memory. It produces two things. The first is a registered pair of operand-bypass selects, one per source, which apply to that instruction once it moves into execute. The second is a stall request. When stall is high, the surrounding pipeline holds fetch and decode and loads a bubble into execute, that is, an instruction with its write-enable and load flags cleared.

The register file writes early in the cycle and reads late in it. A producer that is in writeback while its consumer is in decode therefore needs no bypass. An ALU result is forwarded from the memory or writeback stage without any delay. Only a load followed directly by a consumer costs one stall cycle; the consumer then takes the loaded value from writeback.

The stall sequencer has two states. In ST_FLOW it passes instructions on. A load hazard raises stall and takes the transition ST_FLOW to ST_HOLD. ST_HOLD always returns to ST_FLOW after one cycle, and stall is held low while in ST_HOLD. Write-after-read and write-after-write ordering is safe in this pipeline, so the block does not check it.

Top module: `hz_interlock`

## Requirements
- R1: While reset is asserted and in the first cycle after it, fwd_a and fwd_b are 2'b00 and stall is low.
- R2: A writing producer exactly one instruction ahead of an execute-stage consumer, with a matching non-zero destination, sets that operand's select to 2'b01 (take the value from the memory stage).
- R3: A writing producer exactly two instructions ahead (now in writeback), with a matching non-zero destination, sets the select to 2'b10 (take the value from the writeback stage), unless R5 applies.
- R4: A producer three or more instructions ahead causes no bypass; the select is 2'b00 (register file).
- R5: When both the memory-stage and the writeback-stage producers match an operand, the younger one wins and the select is 2'b01.
- R6: Register 0 never causes a bypass or a stall, even when a producer names it as its destination.
- R7: A producer whose write-enable is low never causes a bypass or a stall, whatever its destination or load flag.
- R8: A writing load in execute whose non-zero destination matches a source of the decode instruction raises stall for exactly one cycle. The consumer then reaches execute with that operand's select at 2'b10.
- R9: No stall is raised for an ALU producer in execute, for a load in execute whose destination matches neither source, or for a load separated from its consumer by one or more instructions.
- R10: In the cycle after a stall, execute holds a bubble and both selects read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_W | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| stall | output | 1 | Hold fetch and decode, and insert a bubble into execute |
| fwd_a | output | 2 | First-operand source for the execute instruction: 00 register file, 01 memory stage, 10 writeback stage |
| fwd_b | output | 2 | Second-operand source, with the same encoding as fwd_a |

## Verification
A behavioural pipeline in the bench runs instruction sequences through the controller and predicts stalls and selects from the distance between producer and consumer.

Directed programs cover the following cases:
- Dependence distances of one, two and three. These separate the memory-stage bypass, the writeback-stage bypass and the register-file read.
- Two back-to-back writers of the same register. This exposes a wrong priority between the two bypass sources.
- Producers that write register 0 or have write-enable low. These must stay invisible.
- A load followed by a consumer, by an unrelated instruction, or by a gap. These separate a needed stall from a spurious one and check that the stall lasts a single cycle.

A long random stream over four registers then mixes all of these cases.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } hz_state_e;

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    output fwd_sel_e         sel_next,
    output logic             load_hit
);

    logic live;
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        live     = (src != '0);
        ex_hit   = live && ex_we && (ex_rd == src);
        mem_hit  = live && mem_we && (mem_rd == src);
        load_hit = ex_hit && ex_load;
        if (ex_hit) begin
            sel_next = FWD_MEM;
        end else if (mem_hit) begin
            sel_next = FWD_WB;
        end else begin
            sel_next = FWD_RF;
        end
    end

endmodule

// File: rtl/hz_ctrl_fsm.sv
module hz_ctrl_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_hit,
    output logic stall
);

    hz_state_e state_q;
    hz_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_FLOW: begin
                if (load_hit) begin
                    stall   = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_FLOW;
            end
        endcase
    end

endmodule

// File: rtl/hz_fwd_regs.sv
module hz_fwd_regs
    import hz_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bubble,
    input  fwd_sel_e sel_next [N_SRC],
    output fwd_sel_e sel_q    [N_SRC]
);

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_sel
            fwd_sel_e q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= FWD_RF;
                end else if (bubble) begin
                    q <= FWD_RF;
                end else begin
                    q <= sel_next[g];
                end
            end
            assign sel_q[g] = q;
        end
    endgenerate

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_we,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_we,
    output logic             stall,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b
);

    localparam int N_SRC = 2;

    logic [REG_W-1:0] srcs [N_SRC];
    fwd_sel_e         sel_next [N_SRC];
    fwd_sel_e         sel_q [N_SRC];
    logic [N_SRC-1:0] load_hits;

    assign srcs[0] = id_rs1;
    assign srcs[1] = id_rs2;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            hz_src_cmp #(.REG_W(REG_W)) i_cmp (
                .src      (srcs[s]),
                .ex_rd    (ex_rd),
                .ex_we    (ex_we),
                .ex_load  (ex_load),
                .mem_rd   (mem_rd),
                .mem_we   (mem_we),
                .sel_next (sel_next[s]),
                .load_hit (load_hits[s])
            );
        end
    endgenerate

    hz_ctrl_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_hit (|load_hits),
        .stall    (stall)
    );

    hz_fwd_regs #(.N_SRC(N_SRC)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bubble   (stall),
        .sel_next (sel_next),
        .sel_q    (sel_q)
    );

    assign fwd_a = sel_q[0];
    assign fwd_b = sel_q[1];

endmodule

// File: rtl/hz_interlock_chk.sv
module hz_interlock_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_rs1,
    input logic [REG_W-1:0] id_rs2,
    input logic [REG_W-1:0] ex_rd,
    input logic             ex_we,
    input logic             ex_load,
    input logic             mem_we,
    input logic             stall,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b
);

    // R8
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R10
    bubble_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fwd_a == 2'b00) && (fwd_b == 2'b00));

    // R6
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |=> (fwd_a == 2'b00));

    // R6
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs2 == '0) |=> (fwd_b == 2'b00));

    // R7
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_we && !mem_we) |=> (fwd_a == 2'b00) && (fwd_b == 2'b00));

    // R8
    stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_load && ex_we && (ex_rd != '0)));

    // R9
    alu_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_load |-> !stall);

    // R2
    sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

endmodule

bind hz_interlock hz_interlock_chk #(.REG_W(REG_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .id_rs1  (id_rs1),
    .id_rs2  (id_rs2),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_load (ex_load),
    .mem_we  (mem_we),
    .stall   (stall),
    .fwd_a   (fwd_a),
    .fwd_b   (fwd_b)
);

// File: tb/test_hz_interlock.sv
`timescale 1ns/1ps
module test_hz_interlock;

    typedef struct {
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [4:0] rd;
        logic       we;
        logic       ld;
    } ins_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
    logic       ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0;
    logic       stall;
    logic [1:0] fwd_a, fwd_b;

    int n_chk = 0;
    int n_fail = 0;
    int stall_cnt;
    bit prev_stall;

    ins_t prog[$];
    ins_t d_s, e_s, m_s, w_s;
    ins_t nop_i = '{rs1: 5'd0, rs2: 5'd0, rd: 5'd0, we: 1'b0, ld: 1'b0};

    always #2 clk = ~clk;

    hz_interlock i_hz_interlock (
        .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
        .mem_rd(mem_rd), .mem_we(mem_we),
        .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_sel(input logic [4:0] rs, input ins_t m, input ins_t w);
        if (rs != 0 && m.we && m.rd == rs) return 1;
        if (rs != 0 && w.we && w.rd == rs) return 2;
        return 0;
    endfunction

    task automatic push(input int rs1, input int rs2, input int rd, input bit we, input bit ld);
        ins_t t;
        t.rs1 = rs1[4:0]; t.rs2 = rs2[4:0]; t.rd = rd[4:0]; t.we = we; t.ld = ld;
        prog.push_back(t);
    endtask

    task automatic step(input string tag);
        bit es;
        int ea, eb;
        @(negedge clk);
        id_rs1 = d_s.rs1; id_rs2 = d_s.rs2;
        ex_rd = e_s.rd; ex_we = e_s.we; ex_load = e_s.ld;
        mem_rd = m_s.rd; mem_we = m_s.we;
        #1;
        es = e_s.ld && e_s.we && e_s.rd != 0 && (e_s.rd == d_s.rs1 || e_s.rd == d_s.rs2);
        ea = exp_sel(e_s.rs1, m_s, w_s);
        eb = exp_sel(e_s.rs2, m_s, w_s);
        check(stall == es, tag, int'(stall), int'(es));
        check(int'(fwd_a) == ea, tag, int'(fwd_a), ea);
        check(int'(fwd_b) == eb, tag, int'(fwd_b), eb);
        if (prev_stall)
            check(fwd_a == 2'b00 && fwd_b == 2'b00, "R10", int'({fwd_a, fwd_b}), 0);
        prev_stall = stall;
        if (stall) stall_cnt++;
        w_s = m_s;
        m_s = e_s;
        if (es) begin
            e_s = nop_i;
        end else begin
            e_s = d_s;
            d_s = (prog.size() > 0) ? prog.pop_front() : nop_i;
        end
    endtask

    task automatic run(input string tag);
        stall_cnt = 0;
        while (prog.size() > 0) step(tag);
        for (int k = 0; k < 5; k++) step(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        d_s = nop_i; e_s = nop_i; m_s = nop_i; w_s = nop_i;
        prev_stall = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(stall == 1'b0 && fwd_a == 2'b00 && fwd_b == 2'b00, "R1", int'({stall, fwd_a, fwd_b}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stall == 1'b0 && fwd_a == 2'b00 && fwd_b == 2'b00, "R1", int'({stall, fwd_a, fwd_b}), 0);

        push(2, 3, 1, 1, 0); push(1, 5, 8, 1, 0);
        run("R2");
        push(2, 3, 1, 1, 0); push(0, 0, 0, 0, 0); push(4, 1, 9, 1, 0);
        run("R3");
        push(2, 3, 1, 1, 0); push(0, 0, 0, 0, 0); push(0, 0, 0, 0, 0); push(1, 1, 9, 1, 0);
        run("R4");
        push(1, 2, 6, 1, 0); push(3, 4, 6, 1, 0); push(6, 6, 10, 1, 0);
        run("R5");
        push(1, 2, 0, 1, 0); push(0, 0, 11, 1, 0); push(8, 0, 0, 1, 1); push(0, 0, 12, 1, 0);
        run("R6");
        check(stall_cnt == 0, "R6", stall_cnt, 0);
        push(1, 2, 7, 0, 0); push(7, 7, 13, 1, 0); push(8, 0, 7, 0, 1); push(7, 7, 14, 1, 0);
        run("R7");
        check(stall_cnt == 0, "R7", stall_cnt, 0);
        push(8, 0, 2, 1, 1); push(2, 2, 3, 1, 0);
        run("R8");
        check(stall_cnt == 1, "R8", stall_cnt, 1);
        push(8, 0, 3, 1, 1); push(4, 5, 15, 1, 0); push(8, 0, 3, 1, 1); push(0, 0, 0, 0, 0);
        push(3, 3, 16, 1, 0); push(2, 3, 4, 1, 0); push(4, 4, 17, 1, 0);
        run("R9");
        check(stall_cnt == 0, "R9", stall_cnt, 0);

        for (int i = 0; i < 3000; i++) begin
            int ld;
            ld = ($urandom_range(0, 2) == 0) ? 1 : 0;
            push($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 4) != 0, ld[0]);
        end
        run("R2");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule